// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on a nibble-wide receive path, downstream of preamble removal and frame check logic. It looks at the destination address that opens every frame and decides whether the station should keep the frame. When filtering is switched on, a frame is kept only if its destination equals the station's own 48-bit address or the all-ones broadcast address. Kept frames leave the block with the destination field removed, so the first output nibble belongs to the source address. Frames addressed elsewhere produce no output and raise an error flag that downstream storage logic uses to throw the frame away.

With filtering switched off, every frame goes through untouched, destination included. The comparison runs while the header streams in, one nibble at a time, against both candidate addresses. The first 48 bits are never buffered. A per-frame abort input stops all output for the rest of the frame. The filter mode is sampled only in the gap between frames, so changing it mid-frame never splits a frame between two behaviours.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `out_en`, `out_bcast` and `out_mismatch` are low.
- R2: In filter mode, a frame whose destination equals `station_addr` is forwarded without its first 12 nibbles. Each forwarded input nibble appears on `out_nib` with `out_en` high exactly one clock after it was taken in. `out_en` falls one clock after `in_en` falls.
- R3: In filter mode, a frame whose destination is all ones is forwarded the same way as in R2. `out_bcast` rises one clock after the 12th nibble and stays high until one clock after `in_en` falls.
- R4: In filter mode, a frame whose destination matches neither candidate drives `out_en` low for the whole frame. `out_mismatch` rises one clock after the first nibble at which neither candidate still agrees with the nibbles received so far. It then stays high until one clock after `in_en` falls.
- R5: The destination arrives byte by byte, first byte `station_addr[47:40]` onward. Within each byte the low nibble comes first, so nibble 0 is compared with `station_addr[43:40]` and nibble 1 with `station_addr[47:44]`.
- R6: In pass mode, every input nibble of a frame appears on `out_nib` with `out_en` high one clock later, and `out_mismatch` never rises.
- R7: `filt_en` is sampled only while `in_en` is low. A change while a frame is in progress affects only the next frame.
- R8: When `in_abort` is high on a clock where `in_en` is high, `out_en`, `out_bcast` and `out_mismatch` are low from the next clock until one clock after `in_en` falls. The following frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| filt_en | input | 1 | 1 selects filter mode, 0 selects pass mode |
| station_addr | input | ADDR_W (48) | Station address, first byte on the wire in bits 47:40 |
| in_en | input | 1 | High for every valid input nibble of a frame |
| in_nib | input | NIB_W (4) | Input nibble |
| in_abort | input | 1 | Abort the current frame |
| out_en | output | 1 | Output nibble valid |
| out_nib | output | NIB_W (4) | Output nibble |
| out_bcast | output | 1 | Current frame is addressed to broadcast |
| out_mismatch | output | 1 | Current frame is addressed to another station |

## Verification
The bench builds the block with its default parameters: 4-bit nibbles, a 48-bit address and the all-ones broadcast value. This gives a 12-nibble header, so every position at which a mismatch can first become certain is reachable from a short frame. Chosen destinations make the decision fall at nibble 0, nibble 6 (a broadcast prefix that breaks late) and nibble 11. A byte with its nibbles swapped tests the nibble order. Mode flips in the middle of a frame and aborts inside and after the header test frame-boundary sampling and abort suppression.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   typedef enum logic {
      MODE_PASS   = 1'b0,
      MODE_FILTER = 1'b1
   } rxf_mode_e;

   localparam int CAND_STATION = 0;
   localparam int CAND_BCAST   = 1;
   localparam int N_CAND       = 2;
endpackage

// File: rtl/rxf_hdr_count.sv
module rxf_hdr_count #(
   parameter int HDR_NIBS = 12,
   localparam int CW      = $clog2(HDR_NIBS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_en,
   output logic [CW-1:0] cnt,
   output logic          in_hdr,
   output logic          last_hdr,
   output logic          hdr_done
);
   localparam logic [CW-1:0] HDR_L  = CW'(HDR_NIBS);
   localparam logic [CW-1:0] LAST_L = CW'(HDR_NIBS - 1);

   generate
      if (HDR_NIBS < 2) begin : g_bad_hdr
         $error("rxf_hdr_count: HDR_NIBS must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !in_en)
         cnt <= '0;
      else if (cnt != HDR_L)
         cnt <= cnt + 1'b1;
   end

   assign in_hdr   = in_en && (cnt != HDR_L);
   assign last_hdr = in_en && (cnt == LAST_L);
   assign hdr_done = in_en && (cnt == HDR_L);

   // R2: the count never runs past the header length
   a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= HDR_L);
   // R2: a new frame always starts counting from zero
   a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !in_en |=> cnt == '0);
endmodule

// File: rtl/rxf_cand_match.sv
module rxf_cand_match #(
   parameter int ADDR_W = 48,
   parameter int NIB_W  = 4,
   parameter int CW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_en,
   input  logic              step,
   input  logic [CW-1:0]     idx,
   input  logic [NIB_W-1:0]  nib,
   input  logic [ADDR_W-1:0] cand,
   output logic              ok_now
);
   localparam int NPB = 8 / NIB_W;

   logic             ok_q;
   logic [NIB_W-1:0] exp_nib;

   generate
      if ((8 % NIB_W) != 0) begin : g_bad_nib
         $error("rxf_cand_match: NIB_W must divide 8");
      end
      if ((ADDR_W % 8) != 0) begin : g_bad_addr
         $error("rxf_cand_match: ADDR_W must be whole bytes");
      end
   endgenerate

   // byte b sits at bits ADDR_W-8-8b up, lower part of the byte goes first
   always_comb begin
      int b;
      int k;
      int base;
      b    = int'(idx) / NPB;
      k    = int'(idx) % NPB;
      base = ADDR_W - 8 - 8 * b + k * NIB_W;
      if (base < 0 || base > ADDR_W - NIB_W)
         base = 0;
      exp_nib = cand[base +: NIB_W];
   end

   assign ok_now = ok_q && (nib == exp_nib);

   always_ff @(posedge clk) begin
      if (!rst_n || !in_en)
         ok_q <= 1'b1;
      else if (step)
         ok_q <= ok_now;
   end

   // R4: once a candidate has been ruled out it stays ruled out for the frame
   a_r4_cand_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      in_en && !ok_q |=> !ok_q || !in_en);
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rxf_pkg::*;
#(
   parameter int                NIB_W      = 4,
   parameter int                ADDR_W     = 48,
   parameter logic [ADDR_W-1:0] BCAST_ADDR = '1,
   localparam int               HDR_NIBS   = ADDR_W / NIB_W,
   localparam int               CW         = $clog2(HDR_NIBS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              filt_en,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic              in_en,
   input  logic [NIB_W-1:0]  in_nib,
   input  logic              in_abort,
   output logic              out_en,
   output logic [NIB_W-1:0]  out_nib,
   output logic              out_bcast,
   output logic              out_mismatch
);
   rxf_mode_e         mode_q;
   logic [CW-1:0]     cnt;
   logic              in_hdr, last_hdr, hdr_done;
   logic              aborted_q, abort_now;
   logic [N_CAND-1:0] cand_ok;
   logic [ADDR_W-1:0] cand_addr [N_CAND];

   generate
      if (NIB_W != 4 && NIB_W != 8) begin : g_bad_w
         $error("rx_dest_filter: NIB_W must be 4 or 8");
      end
   endgenerate

   // mode only follows the configuration while no frame is running
   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= MODE_PASS;
      else if (!in_en)
         mode_q <= filt_en ? MODE_FILTER : MODE_PASS;
   end

   rxf_hdr_count #(.HDR_NIBS(HDR_NIBS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_en    (in_en),
      .cnt      (cnt),
      .in_hdr   (in_hdr),
      .last_hdr (last_hdr),
      .hdr_done (hdr_done)
   );

   assign cand_addr[CAND_STATION] = station_addr;
   assign cand_addr[CAND_BCAST]   = BCAST_ADDR;

   generate
      for (genvar c = 0; c < N_CAND; c++) begin : g_cand
         rxf_cand_match #(.ADDR_W(ADDR_W), .NIB_W(NIB_W), .CW(CW)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_en  (in_en),
            .step   (in_hdr),
            .idx    (cnt),
            .nib    (in_nib),
            .cand   (cand_addr[c]),
            .ok_now (cand_ok[c])
         );
      end
   endgenerate

   assign abort_now = in_abort || aborted_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         aborted_q    <= 1'b0;
         out_en       <= 1'b0;
         out_nib      <= '0;
         out_bcast    <= 1'b0;
         out_mismatch <= 1'b0;
      end else begin
         aborted_q    <= in_en && abort_now;
         out_nib      <= in_nib;
         out_mismatch <= in_en && !abort_now && (mode_q == MODE_FILTER)
                         && (out_mismatch || (in_hdr && (cand_ok == '0)));
         out_bcast    <= in_en && !abort_now && (mode_q == MODE_FILTER)
                         && (out_bcast || (last_hdr && cand_ok[CAND_BCAST]));
         out_en       <= in_en && !abort_now
                         && ((mode_q == MODE_PASS) || (hdr_done && !out_mismatch));
      end
   end

   // R4: a rejected frame never produces output
   a_r4_no_out_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
      out_mismatch |-> !out_en);
   // R4: the mismatch flag holds for the rest of the frame
   a_r4_mismatch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      out_mismatch && in_en && !in_abort |=> out_mismatch);
   // R2: header nibbles are hidden while filtering
   a_r2_hdr_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      in_hdr && mode_q == MODE_FILTER |=> !out_en);
   // R6: pass mode forwards every live nibble
   a_r6_pass_all: assert property (@(posedge clk) disable iff (!rst_n)
      in_en && !abort_now && mode_q == MODE_PASS |=> out_en && !out_mismatch);
   // R7: mode cannot change inside a frame
   a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      in_en && $past(in_en) |-> $stable(mode_q));
   // R8: an abort silences every output on the next clock
   a_r8_abort_silences: assert property (@(posedge clk) disable iff (!rst_n)
      in_abort |=> !out_en && !out_bcast && !out_mismatch);
endmodule

// File: tb/sim_rx_dest_filter.sv
`timescale 1ns/1ps
module sim_rx_dest_filter;
   localparam logic [47:0] STATION = 48'h021A_3C5D_7E9F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        filt_en = 1'b0;
   logic        in_en = 1'b0;
   logic [3:0]  in_nib = '0;
   logic        in_abort = 1'b0;
   logic        out_en, out_bcast, out_mismatch;
   logic [3:0]  out_nib;

   always #4 clk = ~clk;

   rx_dest_filter u0 (
      .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .station_addr(STATION),
      .in_en(in_en), .in_nib(in_nib), .in_abort(in_abort),
      .out_en(out_en), .out_nib(out_nib), .out_bcast(out_bcast),
      .out_mismatch(out_mismatch)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] fb [64];
   int nb;
   int cap [128];
   int cap_n, oe_first, oe_last, mis_first, mis_last, bc_first, bc_last;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] fnib(input int i);
      return (i % 2 == 0) ? fb[i/2][3:0] : fb[i/2][7:4];
   endfunction

   // first header nibble at which no candidate prefix still agrees (R5 order)
   function automatic int exp_bad();
      bit st_ok = 1'b1;
      bit bc_ok = 1'b1;
      for (int i = 0; i < 12; i++) begin
         logic [7:0] sb;
         logic [3:0] sn;
         sb = STATION[47 - 8*(i/2) -: 8];
         sn = (i % 2 == 0) ? sb[3:0] : sb[7:4];
         st_ok = st_ok && (fnib(i) == sn);
         bc_ok = bc_ok && (fnib(i) == 4'hF);
         if (!st_ok && !bc_ok) return i;
      end
      return -1;
   endfunction

   task automatic build(input logic [47:0] dst, input logic [47:0] src,
                        input logic [15:0] et, input int pay);
      for (int b = 0; b < 6; b++) begin
         fb[b]     = dst[47 - 8*b -: 8];
         fb[6 + b] = src[47 - 8*b -: 8];
      end
      fb[12] = et[15:8];
      fb[13] = et[7:0];
      for (int p = 0; p < pay; p++) fb[14 + p] = 8'(p * 7 + 3);
      nb = 14 + pay;
   endtask

   // sample j reflects the nibble driven at step j-1
   task automatic run(input int abort_at, input int flip_at);
      int n;
      n = 2 * nb;
      cap_n = 0; oe_first = -1; oe_last = -1;
      mis_first = -1; mis_last = -1; bc_first = -1; bc_last = -1;
      for (int j = 0; j <= n + 2; j++) begin
         @(negedge clk);
         if (j > 0) begin
            if (out_en) begin
               cap[cap_n] = int'(out_nib); cap_n++;
               if (oe_first < 0) oe_first = j;
               oe_last = j;
            end
            if (out_mismatch) begin
               if (mis_first < 0) mis_first = j;
               mis_last = j;
            end
            if (out_bcast) begin
               if (bc_first < 0) bc_first = j;
               bc_last = j;
            end
         end
         if (j < n) begin
            in_en = 1'b1; in_nib = fnib(j); in_abort = (j == abort_at);
            if (j == flip_at) filt_en = !filt_en;
         end else begin
            in_en = 1'b0; in_abort = 1'b0;
         end
      end
   endtask

   task automatic chk_stream(input string req, input int start, input int count);
      int bad;
      bad = -1;
      chk(cap_n == count, req, "forwarded nibble count", cap_n, count);
      for (int k = 0; k < cap_n && k < count; k++)
         if (bad < 0 && cap[k] != int'(fnib(start + k))) bad = k;
      if (bad >= 0)
         chk(1'b0, req, "forwarded nibble value", cap[bad], int'(fnib(start + bad)));
      else
         chk(1'b1, req, "forwarded nibble value", 0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!out_en, "R1", "out_en after reset", out_en, 0);
      chk(!out_bcast, "R1", "out_bcast after reset", out_bcast, 0);
      chk(!out_mismatch, "R1", "out_mismatch after reset", out_mismatch, 0);
   endtask

   task automatic t_station();
      filt_en = 1'b1;
      build(STATION, 48'hA0B1_C2D3_E4F5, 16'h0800, 10);
      run(-1, -1);
      chk_stream("R2", 12, 2*nb - 12);
      chk(oe_first == 13, "R2", "first out_en sample", oe_first, 13);
      chk(oe_last == 2*nb, "R2", "last out_en sample", oe_last, 2*nb);
      chk(bc_first < 0 && mis_first < 0, "R2", "no flags", bc_first + mis_first, -2);
   endtask

   task automatic t_bcast();
      filt_en = 1'b1;
      build(48'hFFFF_FFFF_FFFF, 48'h1122_3344_5566, 16'h0806, 10);
      run(-1, -1);
      chk_stream("R3", 12, 2*nb - 12);
      chk(bc_first == 12, "R3", "out_bcast rise", bc_first, 12);
      chk(bc_last == 2*nb, "R3", "out_bcast last", bc_last, 2*nb);
   endtask

   task automatic t_mismatch(input logic [47:0] dst, input int want_bad, input string req);
      filt_en = 1'b1;
      build(dst, 48'h1122_3344_5566, 16'h0800, 10);
      chk(exp_bad() == want_bad, req, "bench decision nibble", exp_bad(), want_bad);
      run(-1, -1);
      chk(oe_first < 0, req, "no output on mismatch", oe_first, -1);
      chk(mis_first == want_bad + 1, req, "out_mismatch rise", mis_first, want_bad + 1);
      chk(mis_last == 2*nb, req, "out_mismatch last", mis_last, 2*nb);
   endtask

   task automatic t_pass();
      filt_en = 1'b0;
      build(48'h0000_0000_0001, 48'h1122_3344_5566, 16'h0800, 10);
      run(-1, -1);
      chk_stream("R6", 0, 2*nb);
      chk(oe_first == 1, "R6", "first out_en sample", oe_first, 1);
      chk(mis_first < 0, "R6", "no mismatch in pass mode", mis_first, -1);
   endtask

   task automatic t_mode_flip();
      filt_en = 1'b1;
      build(STATION, 48'h1122_3344_5566, 16'h0800, 10);
      run(-1, 5);
      chk_stream("R7", 12, 2*nb - 12);
      run(-1, -1);
      chk_stream("R7", 0, 2*nb);
      build(48'h0000_0000_0000, 48'h1122_3344_5566, 16'h0800, 10);
      run(-1, 3);
      chk_stream("R7", 0, 2*nb);
      chk(mis_first < 0, "R7", "flip to filter mid-frame ignored", mis_first, -1);
   endtask

   task automatic t_abort();
      filt_en = 1'b1;
      build(STATION, 48'h1122_3344_5566, 16'h0800, 10);
      run(20, -1);
      chk(cap_n == 8, "R8", "nibbles before abort", cap_n, 8);
      chk(oe_last == 20, "R8", "last out_en sample", oe_last, 20);
      build(48'hFFFF_FFFF_FFFF, 48'h1122_3344_5566, 16'h0800, 10);
      run(30, -1);
      chk(bc_last == 30, "R8", "out_bcast cut by abort", bc_last, 30);
      build(48'h0000_0000_0000, 48'h1122_3344_5566, 16'h0800, 10);
      run(4, -1);
      chk(mis_first == 1 && mis_last == 4, "R8", "mismatch cut by abort", mis_last, 4);
      build(STATION, 48'h1122_3344_5566, 16'h0800, 10);
      run(2, -1);
      chk(oe_first < 0 && mis_first < 0, "R8", "abort inside header", oe_first, -1);
      run(-1, -1);
      chk_stream("R8", 12, 2*nb - 12);
   endtask

   initial begin
      #(200000 * 8);
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_station();
      t_bcast();
      t_mismatch(48'h0000_0000_0000, 0, "R4");
      t_mismatch(48'h021A_3C5D_7E1F, 11, "R4");
      t_mismatch(48'hFFFF_FF00_0000, 6, "R4");
      t_mismatch(48'h201A_3C5D_7E9F, 0, "R5");
      t_pass();
      t_mode_flip();
      t_abort();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule